// File: doc/BRIEF.md
# Management Bus Transfer Register Front End

This block is the software-facing half of a two-wire push-pull management bus controller. It sits on an APB slave port and holds the registers that software programs for one bus transaction: the clock divider, the interrupt enables, the target register address inside the slave, the data words, the command code and the slave address pair. A start request hands the transaction to a downstream serial engine over a level request / done-pulse handshake. When the engine finishes, the block records the outcome in write-one-to-clear status flags. It also stores the engine's per-byte error bitmap and copies any read data back into the first data word.

The command code sets both the direction and the width of the transfer. The seven legal codes are decoded here, so the engine receives a read flag, a length code and a flag for the address-assignment command. Any other code fails at once without touching the bus. The start, abort and soft-reset control bits clear themselves. A single interrupt output combines the enabled status flags under a global enable.

Top module: `twb_regfront`

## Requirements
- R1: After the asynchronous reset every register reads 0 and `irq`, `eng_req` and `eng_abort` are 0.
- R2: Writing control bit 7 = 1 with a legal command while idle raises `eng_req` from the next cycle on. Control bit 7 reads 1 until the clock edge that samples `eng_done`, and reads 0 afterwards.
- R3: Writing control bit 7 = 1 while a transfer is active does not restart it. It sets status bit 2 (load busy).
- R4: An `eng_done` pulse with `eng_err` = 0 sets status bit 0 and clears the error-identifier field, status bits 16:8. With `eng_err` = 1 it sets status bit 1 and loads `eng_err_id` into that field: identifier bit k (k = 0..3) marks an error on data byte k+1, and bit 8 marks a missing acknowledge while assigning a run-time address. A clean 8-bit read leaves the status register reading exactly 0x01.
- R5: Writing 1 to status bit 0, 1 or 2 clears that flag. Writing 0 to a flag leaves it unchanged. If a set event and a clear happen in the same cycle, the set wins.
- R6: Command decode: 0x4E, 0x59 and 0x63 are writes with `eng_len` 0, 1 and 2 (1, 2 and 4 bytes). 0x8B, 0x9C and 0xA6 are reads with the same lengths. 0xE8 drives `eng_srta` = 1 with `eng_read` = 0 and `eng_len` = 0.
- R7: A start with any other command code sets status bit 1 with an identifier of 0 in the next cycle. `eng_req` never rises and control bit 7 stays 0.
- R8: A successful read loads the engine's `eng_rdata` into data word 0 (offset 0x1C), low byte first. Bytes beyond the transfer length read 0. A write or address-assignment completion leaves data word 0 unchanged.
- R9: `irq` equals control bit 1 ANDed with the OR of (interrupt-enable bit i AND status bit i) for i = 0..2.
- R10: Writing control bit 6 = 1 ends any active transfer at that edge. `eng_abort` and control bit 6 are 1 for exactly the next cycle, and no status flag is set.
- R11: Writing control bit 0 = 1 drops `eng_req` to 0 in the next cycle, during which control bit 0 reads 1. At the following edge every register except clock control (offset 0x04) returns to 0.
- R12: Clock control (9 bits at 0x04, bits 7:0 on `clk_div`, bit 8 on `cd_delay`), interrupt enable (3 bits at 0x08), register address (8 bits at 0x10), data words (0x1C, 0x20), command (8 bits at 0x2C) and slave address (24 bits at 0x30: run-time address in 23:16, hardware address in 15:0) read back what was written. Offsets 0x24 and 0x28 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| clk_div | output | 8 | Serial clock divider value |
| cd_delay | output | 1 | Output delay select for the data line |
| bus_mode | output | 1 | Bus mode select (control bit 8) |
| irq | output | 1 | Interrupt |
| eng_req | output | 1 | Transaction request, held while active |
| eng_abort | output | 1 | One-cycle abort pulse |
| eng_read | output | 1 | Transfer is a read |
| eng_srta | output | 1 | Transfer assigns a run-time address |
| eng_len | output | 2 | Length code: 0 = 1, 1 = 2, 2 = 4 bytes |
| eng_reg_addr | output | RA_W | Register address within the slave |
| eng_wdata | output | 32 | Write data (data word 0) |
| eng_rt_addr | output | 8 | Run-time slave address |
| eng_hw_addr | output | 16 | Hardware slave address |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Completion carried an error |
| eng_err_id | input | 9 | Per-byte / no-acknowledge error bitmap |
| eng_rdata | input | 32 | Read data returned by the engine |

## Verification
The embedded properties check on every cycle the following: a completion or an abort drops the active state, and a bad-command start never becomes active. Each event sets its status flag, a write-one clear takes effect, and a soft reset keeps the clock control word. Whether the command decode, the width masking of returned read data, the interrupt combination and the exact status words are right can only be shown by the bench. Its randomized transactions cover legal and illegal codes, error bitmaps and enable masks, and directed scenarios cover a start while busy, an abort and a soft reset.

// File: rtl/twb_pkg.sv
package twb_pkg;
  localparam logic [7:0] OP_WR8  = 8'h4E;
  localparam logic [7:0] OP_WR16 = 8'h59;
  localparam logic [7:0] OP_WR32 = 8'h63;
  localparam logic [7:0] OP_RD8  = 8'h8B;
  localparam logic [7:0] OP_RD16 = 8'h9C;
  localparam logic [7:0] OP_RD32 = 8'hA6;
  localparam logic [7:0] OP_SRTA = 8'hE8;

  // word index (byte offset / 4)
  localparam logic [5:0] W_CTRL  = 6'h00;
  localparam logic [5:0] W_CLK   = 6'h01;
  localparam logic [5:0] W_IEN   = 6'h02;
  localparam logic [5:0] W_STAT  = 6'h03;
  localparam logic [5:0] W_RADDR = 6'h04;
  localparam logic [5:0] W_DAT0  = 6'h07;
  localparam logic [5:0] W_DAT1  = 6'h08;
  localparam logic [5:0] W_CMD   = 6'h0B;
  localparam logic [5:0] W_SADDR = 6'h0C;

  localparam int unsigned ERR_ID_W = 9;
  localparam int unsigned NFLAG    = 3;

  typedef enum logic [1:0] {
    LEN_1B = 2'd0,
    LEN_2B = 2'd1,
    LEN_4B = 2'd2
  } len_e;

  typedef struct packed {
    logic ok;
    logic rd;
    logic srta;
    len_e len;
  } cmd_t;
endpackage

// File: rtl/twb_cmd_dec.sv
module twb_cmd_dec
  import twb_pkg::*;
(
  input  logic [7:0] code,
  output cmd_t       dec
);
  always_comb begin
    dec = '{ok: 1'b1, rd: 1'b0, srta: 1'b0, len: LEN_1B};
    unique case (code)
      OP_WR8:  dec.len = LEN_1B;
      OP_WR16: dec.len = LEN_2B;
      OP_WR32: dec.len = LEN_4B;
      OP_RD8:  begin dec.rd = 1'b1; dec.len = LEN_1B; end
      OP_RD16: begin dec.rd = 1'b1; dec.len = LEN_2B; end
      OP_RD32: begin dec.rd = 1'b1; dec.len = LEN_4B; end
      OP_SRTA: dec.srta = 1'b1;
      default: dec.ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/twb_xfer_ctrl.sv
module twb_xfer_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_wr,
  input  logic abort_wr,
  input  logic srst_wr,
  input  logic cmd_ok,
  input  logic eng_done,
  input  logic eng_err,
  output logic busy,
  output logic abort_q,
  output logic srst_q,
  output logic eng_req,
  output logic ev_ok,
  output logic ev_err,
  output logic ev_bad,
  output logic ev_lbsy
);
  logic busy_d, abort_d, srst_d;

  always_comb begin
    busy_d  = busy;
    abort_d = 1'b0;
    srst_d  = 1'b0;
    ev_ok   = 1'b0;
    ev_err  = 1'b0;
    ev_bad  = 1'b0;
    ev_lbsy = 1'b0;
    if (srst_q) begin
      busy_d = 1'b0;
    end else begin
      if (busy && eng_done) begin
        busy_d = 1'b0;
        ev_ok  = ~eng_err;
        ev_err = eng_err;
      end
      if (abort_wr) begin
        busy_d  = 1'b0;
        abort_d = 1'b1;
      end
      if (start_wr) begin
        if (busy)         ev_lbsy = 1'b1;
        else if (!cmd_ok) ev_bad  = 1'b1;
        else if (!abort_wr) busy_d = 1'b1;
      end
      if (srst_wr) srst_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      abort_q <= 1'b0;
      srst_q  <= 1'b0;
    end else begin
      busy    <= busy_d;
      abort_q <= abort_d;
      srst_q  <= srst_d;
    end
  end

  assign eng_req = busy & ~srst_q;

  // R2: a completion ends the active transfer
  p_done_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && eng_done && !start_wr |=> !busy);
  // R7: an illegal command never becomes active
  p_bad_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr && !cmd_ok && !busy |=> !busy);
  // R10: abort ends the transfer
  p_abort_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr |=> !busy && abort_q);
  // R11: soft reset leaves the handshake idle
  p_srst_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !busy);
endmodule

// File: rtl/twb_stat_irq.sv
module twb_stat_irq
  import twb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                srst_q,
  input  logic                clr_wr,
  input  logic [NFLAG-1:0]    clr_mask,
  input  logic                ev_ok,
  input  logic                ev_err,
  input  logic                ev_bad,
  input  logic                ev_lbsy,
  input  logic [ERR_ID_W-1:0] eng_err_id,
  input  logic [NFLAG-1:0]    ien,
  input  logic                gie,
  output logic [NFLAG-1:0]    flags,
  output logic [ERR_ID_W-1:0] err_id,
  output logic                irq
);
  logic [NFLAG-1:0]    flags_d;
  logic [ERR_ID_W-1:0] err_id_d;

  always_comb begin
    flags_d  = flags;
    err_id_d = err_id;
    if (srst_q) begin
      flags_d  = '0;
      err_id_d = '0;
    end else begin
      if (clr_wr) flags_d = flags & ~clr_mask;
      if (ev_ok)           flags_d[0] = 1'b1;
      if (ev_err || ev_bad) flags_d[1] = 1'b1;
      if (ev_lbsy)         flags_d[2] = 1'b1;
      if (ev_ok || ev_bad) err_id_d = '0;
      else if (ev_err)     err_id_d = eng_err_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= '0;
      err_id <= '0;
    end else begin
      flags  <= flags_d;
      err_id <= err_id_d;
    end
  end

  assign irq = gie & |(ien & flags);

  // R4: completion flags follow engine outcome
  p_ok_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ok |=> flags[0] && (err_id == '0));
  p_err_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> flags[1] && (err_id == $past(eng_err_id)));
  // R3: start while busy flags load busy
  p_lbsy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lbsy |=> flags[2]);
  // R5: write-one clears when no set competes
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && clr_mask[0] && !ev_ok |=> !flags[0]);
endmodule

// File: rtl/twb_regfront.sv
module twb_regfront
  import twb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned RA_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [31:0]         pwdata,
  output logic [31:0]         prdata,
  output logic [7:0]          clk_div,
  output logic                cd_delay,
  output logic                bus_mode,
  output logic                irq,
  output logic                eng_req,
  output logic                eng_abort,
  output logic                eng_read,
  output logic                eng_srta,
  output logic [1:0]          eng_len,
  output logic [RA_W-1:0]     eng_reg_addr,
  output logic [31:0]         eng_wdata,
  output logic [7:0]          eng_rt_addr,
  output logic [15:0]         eng_hw_addr,
  input  logic                eng_done,
  input  logic                eng_err,
  input  logic [ERR_ID_W-1:0] eng_err_id,
  input  logic [31:0]         eng_rdata
);
  localparam int unsigned CLK_W  = 9;
  localparam int unsigned SADR_W = 24;

  logic [5:0] widx;
  logic       wr_en;
  logic       wr_ctrl, wr_clk, wr_ien, wr_stat, wr_raddr, wr_dat0, wr_dat1, wr_cmd, wr_sadr;

  logic [CLK_W-1:0]  clk_q, clk_d;
  logic [NFLAG-1:0]  ien_q, ien_d;
  logic [RA_W-1:0]   raddr_q, raddr_d;
  logic [31:0]       dat0_q, dat0_d, dat1_q, dat1_d, rd_mask;
  logic [7:0]        cmd_q, cmd_d;
  logic [SADR_W-1:0] sadr_q, sadr_d;
  logic              gie_q, gie_d, mode_q, mode_d;

  cmd_t              dec;
  logic              busy, abort_q, srst_q;
  logic              ev_ok, ev_err, ev_bad, ev_lbsy;
  logic [NFLAG-1:0]  flags;
  logic [ERR_ID_W-1:0] err_id;

  assign widx     = paddr[7:2];
  assign wr_en    = psel & penable & pwrite;
  assign wr_ctrl  = wr_en && (widx == W_CTRL);
  assign wr_clk   = wr_en && (widx == W_CLK);
  assign wr_ien   = wr_en && (widx == W_IEN);
  assign wr_stat  = wr_en && (widx == W_STAT);
  assign wr_raddr = wr_en && (widx == W_RADDR);
  assign wr_dat0  = wr_en && (widx == W_DAT0);
  assign wr_dat1  = wr_en && (widx == W_DAT1);
  assign wr_cmd   = wr_en && (widx == W_CMD);
  assign wr_sadr  = wr_en && (widx == W_SADDR);

  twb_cmd_dec u_dec (
    .code (cmd_q),
    .dec  (dec)
  );

  twb_xfer_ctrl u_xfer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_wr (wr_ctrl & pwdata[7]),
    .abort_wr (wr_ctrl & pwdata[6]),
    .srst_wr  (wr_ctrl & pwdata[0]),
    .cmd_ok   (dec.ok),
    .eng_done (eng_done),
    .eng_err  (eng_err),
    .busy     (busy),
    .abort_q  (abort_q),
    .srst_q   (srst_q),
    .eng_req  (eng_req),
    .ev_ok    (ev_ok),
    .ev_err   (ev_err),
    .ev_bad   (ev_bad),
    .ev_lbsy  (ev_lbsy)
  );

  twb_stat_irq u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .srst_q     (srst_q),
    .clr_wr     (wr_stat),
    .clr_mask   (pwdata[NFLAG-1:0]),
    .ev_ok      (ev_ok),
    .ev_err     (ev_err),
    .ev_bad     (ev_bad),
    .ev_lbsy    (ev_lbsy),
    .eng_err_id (eng_err_id),
    .ien        (ien_q),
    .gie        (gie_q),
    .flags      (flags),
    .err_id     (err_id),
    .irq        (irq)
  );

  always_comb begin
    unique case (dec.len)
      LEN_1B:  rd_mask = 32'h0000_00FF;
      LEN_2B:  rd_mask = 32'h0000_FFFF;
      default: rd_mask = 32'hFFFF_FFFF;
    endcase
  end

  // next-state for the register file
  always_comb begin
    clk_d   = wr_clk   ? pwdata[CLK_W-1:0]  : clk_q;
    ien_d   = wr_ien   ? pwdata[NFLAG-1:0]  : ien_q;
    raddr_d = wr_raddr ? pwdata[RA_W-1:0]   : raddr_q;
    dat0_d  = wr_dat0  ? pwdata             : dat0_q;
    dat1_d  = wr_dat1  ? pwdata             : dat1_q;
    cmd_d   = wr_cmd   ? pwdata[7:0]        : cmd_q;
    sadr_d  = wr_sadr  ? pwdata[SADR_W-1:0] : sadr_q;
    gie_d   = wr_ctrl  ? pwdata[1]          : gie_q;
    mode_d  = wr_ctrl  ? pwdata[8]          : mode_q;
    if (ev_ok && dec.rd) dat0_d = eng_rdata & rd_mask;
    if (srst_q) begin
      ien_d   = '0;
      raddr_d = '0;
      dat0_d  = '0;
      dat1_d  = '0;
      cmd_d   = '0;
      sadr_d  = '0;
      gie_d   = 1'b0;
      mode_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q   <= '0;
      ien_q   <= '0;
      raddr_q <= '0;
      dat0_q  <= '0;
      dat1_q  <= '0;
      cmd_q   <= '0;
      sadr_q  <= '0;
      gie_q   <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      clk_q   <= clk_d;
      ien_q   <= ien_d;
      raddr_q <= raddr_d;
      dat0_q  <= dat0_d;
      dat1_q  <= dat1_d;
      cmd_q   <= cmd_d;
      sadr_q  <= sadr_d;
      gie_q   <= gie_d;
      mode_q  <= mode_d;
    end
  end

  always_comb begin
    prdata = '0;
    if (psel) begin
      unique case (widx)
        W_CTRL:  prdata = {23'b0, mode_q, busy, abort_q, 4'b0, gie_q, srst_q};
        W_CLK:   prdata = {{(32-CLK_W){1'b0}}, clk_q};
        W_IEN:   prdata = {{(32-NFLAG){1'b0}}, ien_q};
        W_STAT:  prdata = {{(24-ERR_ID_W){1'b0}}, err_id, 5'b0, flags};
        W_RADDR: prdata = {{(32-RA_W){1'b0}}, raddr_q};
        W_DAT0:  prdata = dat0_q;
        W_DAT1:  prdata = dat1_q;
        W_CMD:   prdata = {24'b0, cmd_q};
        W_SADDR: prdata = {{(32-SADR_W){1'b0}}, sadr_q};
        default: prdata = '0;
      endcase
    end
  end

  assign clk_div      = clk_q[7:0];
  assign cd_delay     = clk_q[8];
  assign bus_mode     = mode_q;
  assign eng_abort    = abort_q;
  assign eng_read     = dec.rd;
  assign eng_srta     = dec.srta;
  assign eng_len      = dec.len;
  assign eng_reg_addr = raddr_q;
  assign eng_wdata    = dat0_q;
  assign eng_rt_addr  = sadr_q[23:16];
  assign eng_hw_addr  = sadr_q[15:0];

  logic unused_bits;
  assign unused_bits = ^{paddr[1:0], pwdata[31:CLK_W], pwdata[5:2], dec.ok};

  // R11: clock control survives soft reset
  p_clk_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q && !wr_clk |=> $stable(clk_q));
  // R8: single-byte read returns zero upper bytes
  p_rd8_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ok && dec.rd && (dec.len == LEN_1B) && !srst_q |=> dat0_q[31:8] == 24'h0);
endmodule

// File: tb/twb_regfront_tb.sv
module twb_regfront_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [7:0]  clk_div;
  logic        cd_delay, bus_mode, irq, eng_req, eng_abort, eng_read, eng_srta;
  logic [1:0]  eng_len;
  logic [7:0]  eng_reg_addr, eng_rt_addr;
  logic [31:0] eng_wdata;
  logic [15:0] eng_hw_addr;
  logic        eng_done = 0, eng_err = 0;
  logic [8:0]  eng_err_id = '0;
  logic [31:0] eng_rdata = '0;

  int checks = 0, fails = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  twb_regfront u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .clk_div(clk_div),
    .cd_delay(cd_delay), .bus_mode(bus_mode), .irq(irq), .eng_req(eng_req),
    .eng_abort(eng_abort), .eng_read(eng_read), .eng_srta(eng_srta),
    .eng_len(eng_len), .eng_reg_addr(eng_reg_addr), .eng_wdata(eng_wdata),
    .eng_rt_addr(eng_rt_addr), .eng_hw_addr(eng_hw_addr), .eng_done(eng_done),
    .eng_err(eng_err), .eng_err_id(eng_err_id), .eng_rdata(eng_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  // engine model: wait for request, then one done pulse
  task automatic finish_xfer(input bit err, input logic [8:0] id, input logic [31:0] rd,
                             input int dly);
    int guard = 0;
    while (!eng_req && guard < 100) begin @(negedge clk); guard++; end
    repeat (dly) @(negedge clk);
    eng_done = 1; eng_err = err; eng_err_id = id; eng_rdata = rd;
    @(negedge clk);
    eng_done = 0; eng_err = 0;
  endtask

  // expected decode: {ok, rd, srta, len}
  function automatic logic [4:0] exp_dec(input logic [7:0] c);
    case (c)
      8'h4E: return 5'b1_0_0_00;
      8'h59: return 5'b1_0_0_01;
      8'h63: return 5'b1_0_0_10;
      8'h8B: return 5'b1_1_0_00;
      8'h9C: return 5'b1_1_0_01;
      8'hA6: return 5'b1_1_0_10;
      8'hE8: return 5'b1_0_1_00;
      default: return 5'b0_0_0_00;
    endcase
  endfunction

  function automatic logic [31:0] exp_mask(input logic [1:0] len);
    return (len == 2'd0) ? 32'hFF : (len == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, d0_exp;
    logic [7:0] legal [7];
    legal = '{8'h4E, 8'h59, 8'h63, 8'h8B, 8'h9C, 8'hA6, 8'hE8};
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    foreach (legal[k]) begin end
    for (int a = 0; a <= 8'h30; a += 4) begin
      apb_rd(a[7:0], r);
      chk("R1 reset read", r, 32'h0);
    end
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 eng_req", {31'b0, eng_req}, 0);
    chk("R1 eng_abort", {31'b0, eng_abort}, 0);

    // R12 storage
    apb_wr(8'h04, 32'hFFFF_F103);
    apb_rd(8'h04, r); chk("R12 clock ctrl", r, 32'h103);
    chk("R12 clk_div/cd_delay", {23'b0, cd_delay, clk_div}, 32'h103);
    apb_wr(8'h30, 32'hAB2D_03A3);
    apb_rd(8'h30, r); chk("R12 slave addr", r, 32'h002D_03A3);
    chk("R12 rt/hw", {8'b0, eng_rt_addr, eng_hw_addr}, 32'h002D_03A3);
    apb_wr(8'h20, 32'hDEAD_BEEF);
    apb_rd(8'h20, r); chk("R12 data1", r, 32'hDEAD_BEEF);
    apb_wr(8'h24, 32'hFFFF_FFFF); apb_rd(8'h24, r); chk("R12 line ctrl zero", r, 0);
    apb_wr(8'h28, 32'hFFFF_FFFF); apb_rd(8'h28, r); chk("R12 init zero", r, 0);
    apb_wr(8'h10, 32'h0000_0142); apb_rd(8'h10, r); chk("R12 reg addr", r, 32'h42);
    apb_wr(8'h00, 32'h0000_0100); chk("R12 bus_mode", {31'b0, bus_mode}, 1);

    // R2 / R3 / R4: clean RD8 with a start while busy
    apb_wr(8'h2C, 32'h8B);
    apb_wr(8'h00, 32'h80);
    chk("R2 req after start", {31'b0, eng_req}, 1);
    apb_rd(8'h00, r); chk("R2 start bit busy", r & 32'h80, 32'h80);
    apb_wr(8'h00, 32'h80);
    chk("R3 still active", {31'b0, eng_req}, 1);
    finish_xfer(0, 9'h1FF, 32'h1234_5678, 2);
    chk("R2 req dropped", {31'b0, eng_req}, 0);
    apb_rd(8'h00, r); chk("R2 start bit clear", r & 32'h80, 0);
    apb_rd(8'h0C, r); chk("R3 load busy + done", r, 32'h5);
    apb_rd(8'h1C, r); chk("R8 rd8 data", r, 32'h78);
    apb_wr(8'h0C, 32'h4);
    apb_rd(8'h0C, r); chk("R4 clean rd8 status", r, 32'h1);

    // R5 W1C
    apb_wr(8'h0C, 32'h2);
    apb_rd(8'h0C, r); chk("R5 zero write keeps", r, 32'h1);
    apb_wr(8'h0C, 32'h1);
    apb_rd(8'h0C, r); chk("R5 one clears", r, 32'h0);

    // R10 abort
    apb_wr(8'h2C, 32'h63);
    apb_wr(8'h00, 32'h80);
    apb_wr(8'h00, 32'h40);
    chk("R10 abort pulse", {30'b0, eng_abort, eng_req}, 32'h2);
    @(negedge clk);
    chk("R10 abort one cycle", {31'b0, eng_abort}, 0);
    apb_rd(8'h00, r); chk("R10 ctrl after abort", r & 32'hC0, 0);
    apb_rd(8'h0C, r); chk("R10 no status", r, 0);

    // R7 illegal command
    apb_wr(8'h2C, 32'h55);
    apb_wr(8'h00, 32'h80);
    chk("R7 no request", {31'b0, eng_req}, 0);
    apb_rd(8'h00, r); chk("R7 start bit zero", r & 32'h80, 0);
    apb_rd(8'h0C, r); chk("R7 error flag", r, 32'h2);
    apb_wr(8'h0C, 32'h7);

    // randomized transactions
    d0_exp = 32'h0;
    for (int i = 0; i < 40; i++) begin
      logic [7:0] c;
      logic [4:0] e;
      logic [2:0] ien;
      logic gie, err;
      logic [8:0] id;
      logic [31:0] rd, st_exp, wd;
      c   = ($urandom % 4 == 0) ? 8'($urandom) : legal[$urandom % 7];
      e   = exp_dec(c);
      ien = 3'($urandom); gie = 1'($urandom); err = 1'($urandom);
      id  = 9'($urandom); rd = $urandom; wd = $urandom;
      apb_wr(8'h2C, {24'b0, c});
      apb_wr(8'h1C, wd); d0_exp = wd;
      apb_wr(8'h08, {29'b0, ien});
      apb_wr(8'h0C, 32'h7);
      if (e[4]) begin
        chk("R6 decode", {27'b0, eng_read, eng_srta, 1'b0, eng_len}, {27'b0, e[3], e[2], 1'b0, e[1:0]});
        apb_wr(8'h00, {30'b0, gie, 1'b0} | 32'h80);
        finish_xfer(err, id, rd, int'($urandom % 4));
        st_exp = err ? ({23'b0, id} << 8) | 32'h2 : 32'h1;
        if (!err && e[3]) d0_exp = rd & exp_mask(e[1:0]);
        apb_rd(8'h0C, r); chk("R4 status", r, st_exp);
        apb_rd(8'h1C, r); chk("R8 data0", r, d0_exp);
      end else begin
        apb_wr(8'h00, {30'b0, gie, 1'b0} | 32'h80);
        chk("R7 no request", {31'b0, eng_req}, 0);
        st_exp = 32'h2;
        apb_rd(8'h0C, r); chk("R7 status", r, st_exp);
      end
      chk("R9 irq", {31'b0, irq}, {31'b0, gie & |(ien & st_exp[2:0])});
    end

    // R11 soft reset
    apb_wr(8'h04, 32'h105);
    apb_wr(8'h08, 32'h7);
    apb_wr(8'h2C, 32'h9C);
    apb_wr(8'h00, 32'h182);
    apb_wr(8'h00, 32'h183);
    chk("R11 req dropped", {31'b0, eng_req}, 0);
    @(negedge clk);
    apb_rd(8'h04, r); chk("R11 clock kept", r, 32'h105);
    apb_rd(8'h08, r); chk("R11 ien cleared", r, 0);
    apb_rd(8'h00, r); chk("R11 ctrl cleared", r, 0);
    apb_rd(8'h1C, r); chk("R11 data0 cleared", r, 0);
    apb_rd(8'h2C, r); chk("R11 cmd cleared", r, 0);
    apb_rd(8'h30, r); chk("R11 saddr cleared", r, 0);
    chk("R11 irq low", {31'b0, irq}, 0);

    done_flag = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule